// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. Each cycle it looks at four inputs: the pending request vector, the mask vector, the in-service vector and a rotation base. It works out whether a request that is pending and not masked outranks every interrupt now being serviced. When one does, it raises a valid flag and gives that request's line number. A registered copy of the valid flag drives the interrupt pin.

Priority is not fixed. The line at the rotation base has the highest rank, and rank falls as the line number rises, wrapping modulo the line count. Command logic outside the block moves the base to get rotating priority. Two options change how the in-service vector is read. The special-mask option leaves out serviced lines that are currently masked. On a master unit, the nested-cascade option leaves out the cascade line, so that a slave unit can nest its own interrupts.

Request capture, acknowledge sequencing and register access all belong to the surrounding controller.

Top module: `rot_prio_resolver`

## Requirements
- R1: The rank of line n is (n - base) mod 8, and rank 0 is the most urgent. Among the candidate lines, the one with the smallest rank wins. line_o gives the winning line number in binary.
- R2: A line is a candidate when req_i[n]=1 and mask_i[n]=0, so a mask bit of 1 blocks its line. With no candidates, valid_o is 0.
- R3: When the effective in-service vector is empty, it counts as rank 8, and any candidate produces valid_o=1.
- R4: valid_o is 1 only when the best candidate's rank is strictly smaller than the lowest rank among the effective in-service lines. If the two ranks are equal, or the in-service rank is better, valid_o is 0.
- R5: With special_mask_i=1, an in-service line whose mask_i bit is 1 is left out of the in-service rank. With special_mask_i=0, every in-service bit counts.
- R6: With nest_cascade_i=1 and is_master_i=1, in-service bit 2 (the cascade line) is left out of the in-service rank. It counts whenever either input is 0.
- R7: irq_o is 0 while rst_n is low. After reset, irq_o takes the value valid_o had at each rising clock edge.
- R8: When valid_o is 0, line_o is 0.
- R9: valid_o and line_o are combinational and settle in the same cycle for every one of the eight base values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector, 1 = blocked |
| isr_i | input | 8 | In-service vector |
| base_i | input | 3 | Rotation base (rank-0 line) |
| special_mask_i | input | 1 | Leave masked in-service lines out of the in-service rank |
| nest_cascade_i | input | 1 | Leave the cascade in-service bit out (master only) |
| is_master_i | input | 1 | Unit is the cascade master |
| valid_o | output | 1 | A candidate outranks the in-service level |
| line_o | output | 3 | Winning line number, 0 when not valid |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench sweeps every request vector against every in-service vector at all eight bases. This finds a resolver that compares ranks with less-than-or-equal and so re-grants the line already in service. It also finds one that rotates the wrong way or drops the modulo wrap, which then reports the wrong line whenever the base is not zero. Random patterns with both in-service options enabled find a special-mask filter that is ignored or inverted, and a cascade exclusion that also fires on a slave unit. Either fault suppresses or grants interrupts that should go the other way. Directed edge-aligned checks find an interrupt pin that is not registered, or that is registered twice, because it then moves a cycle early or a cycle late against valid_o.

// File: rtl/rpr_pkg.sv
`timescale 1ns/1ps
package rpr_pkg;
  localparam int unsigned LINES_DEFAULT   = 8;
  localparam int unsigned CASCADE_DEFAULT = 2;

  // modular sum of two indices for a ring of n lines
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) % n;
  endfunction

  // distance of line idx behind the rotation base, i.e. its rank
  function automatic int unsigned ring_rank(int unsigned idx, int unsigned base, int unsigned n);
    return (idx + n - (base % n)) % n;
  endfunction
endpackage

// File: rtl/prio_rotate.sv
`timescale 1ns/1ps
// Output bit r holds the input bit of the line whose rank is r.
module prio_rotate #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IDX_W-1:0]   base_i,
  output logic [N_LINES-1:0] vec_o
);
  import rpr_pkg::*;

  for (genvar g = 0; g < N_LINES; g++) begin : g_rank
    logic [IDX_W-1:0] src_idx;
    assign src_idx   = IDX_W'(ring_add(g, int'(base_i), N_LINES));
    assign vec_o[g]  = vec_i[src_idx];
  end
endmodule

// File: rtl/prio_first.sv
`timescale 1ns/1ps
// Lowest set bit index; N_LINES when the vector is empty.
module prio_first #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned RANK_W = $clog2(N_LINES + 1)
) (
  input  logic [N_LINES-1:0] vec_i,
  output logic [RANK_W-1:0]  rank_o,
  output logic               found_o
);
  always_comb begin
    rank_o = RANK_W'(N_LINES);
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (vec_i[i]) rank_o = RANK_W'(i);
    end
  end

  assign found_o = |vec_i;
endmodule

// File: rtl/isr_filter.sv
`timescale 1ns/1ps
// Builds the in-service vector that takes part in the rank comparison.
module isr_filter #(
  parameter int unsigned N_LINES      = 8,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic [N_LINES-1:0] isr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               special_mask_i,
  input  logic               nest_cascade_i,
  input  logic               is_master_i,
  output logic [N_LINES-1:0] isr_eff_o
);
  logic [N_LINES-1:0] smm_drop;
  logic [N_LINES-1:0] cas_drop;

  assign smm_drop = special_mask_i ? mask_i : '0;

  if (CASCADE_LINE < N_LINES) begin : g_cascade
    always_comb begin
      cas_drop = '0;
      cas_drop[CASCADE_LINE] = nest_cascade_i & is_master_i;
    end
  end else begin : g_no_cascade
    logic unused_cas;
    assign unused_cas = nest_cascade_i ^ is_master_i;
    assign cas_drop   = '0;
  end

  assign isr_eff_o = isr_i & ~smm_drop & ~cas_drop;
endmodule

// File: rtl/rot_prio_resolver.sv
`timescale 1ns/1ps
module rot_prio_resolver #(
  parameter int unsigned N_LINES      = rpr_pkg::LINES_DEFAULT,
  parameter int unsigned CASCADE_LINE = rpr_pkg::CASCADE_DEFAULT,
  localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int unsigned RANK_W = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic [IDX_W-1:0]   base_i,
  input  logic               special_mask_i,
  input  logic               nest_cascade_i,
  input  logic               is_master_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   line_o,
  output logic               irq_o
);
  import rpr_pkg::*;

  // named internal events
  logic [N_LINES-1:0] cand_vec;
  logic [N_LINES-1:0] isr_eff;
  logic [N_LINES-1:0] cand_rot;
  logic [N_LINES-1:0] isr_rot;
  logic [RANK_W-1:0]  cand_rank;
  logic [RANK_W-1:0]  svc_rank;
  logic               cand_found;
  logic               svc_found;
  logic               win;

  assign cand_vec = req_i & ~mask_i;

  isr_filter #(.N_LINES(N_LINES), .CASCADE_LINE(CASCADE_LINE)) u_filter (
    .isr_i          (isr_i),
    .mask_i         (mask_i),
    .special_mask_i (special_mask_i),
    .nest_cascade_i (nest_cascade_i),
    .is_master_i    (is_master_i),
    .isr_eff_o      (isr_eff)
  );

  prio_rotate #(.N_LINES(N_LINES)) u_rot_cand (
    .vec_i (cand_vec), .base_i (base_i), .vec_o (cand_rot)
  );
  prio_rotate #(.N_LINES(N_LINES)) u_rot_isr (
    .vec_i (isr_eff), .base_i (base_i), .vec_o (isr_rot)
  );

  prio_first #(.N_LINES(N_LINES)) u_first_cand (
    .vec_i (cand_rot), .rank_o (cand_rank), .found_o (cand_found)
  );
  prio_first #(.N_LINES(N_LINES)) u_first_isr (
    .vec_i (isr_rot), .rank_o (svc_rank), .found_o (svc_found)
  );

  assign win     = cand_found & (!svc_found | (cand_rank < svc_rank));
  assign valid_o = win;
  assign line_o  = win ? IDX_W'(ring_add(int'(cand_rank), int'(base_i), N_LINES)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= win;
  end
endmodule

// File: rtl/rpr_checker.sv
`timescale 1ns/1ps
module rpr_checker #(
  parameter int unsigned N_LINES      = 8,
  parameter int unsigned CASCADE_LINE = 2,
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] req_i,
  input logic [N_LINES-1:0] mask_i,
  input logic [N_LINES-1:0] isr_i,
  input logic [IDX_W-1:0]   base_i,
  input logic               special_mask_i,
  input logic               nest_cascade_i,
  input logic               is_master_i,
  input logic               valid_o,
  input logic [IDX_W-1:0]   line_o,
  input logic               irq_o
);
  import rpr_pkg::*;

  logic [N_LINES-1:0] open_req;
  logic [N_LINES-1:0] svc_seen;
  logic               better_exists;
  logic               blocked;
  int unsigned        win_rank;

  assign open_req = req_i & ~mask_i;

  always_comb begin
    svc_seen = isr_i;
    for (int n = 0; n < N_LINES; n++) begin
      if (special_mask_i && mask_i[n]) svc_seen[n] = 1'b0;
      if (n == CASCADE_LINE && nest_cascade_i && is_master_i) svc_seen[n] = 1'b0;
    end
    win_rank      = ring_rank(int'(line_o), int'(base_i), N_LINES);
    better_exists = 1'b0;
    blocked       = 1'b0;
    for (int n = 0; n < N_LINES; n++) begin
      if (open_req[n] && ring_rank(n, int'(base_i), N_LINES) < win_rank) better_exists = 1'b1;
      if (svc_seen[n] && ring_rank(n, int'(base_i), N_LINES) <= win_rank) blocked = 1'b1;
    end
  end

  a_r1_no_better_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !better_exists);
  a_r2_line_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> open_req[line_o]);
  a_r2_empty_none: assert property (@(posedge clk) disable iff (!rst_n)
    (open_req == '0) |-> !valid_o);
  a_r3_idle_service_grants: assert property (@(posedge clk) disable iff (!rst_n)
    ((open_req != '0) && (isr_i == '0)) |-> valid_o);
  // covers R4 together with the R5 and R6 filtering of the in-service vector
  a_r4_service_not_outranked: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !blocked);
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(valid_o)));
  a_r8_line_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (line_o == '0));
endmodule

bind rot_prio_resolver rpr_checker #(.N_LINES(N_LINES), .CASCADE_LINE(CASCADE_LINE)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_i          (req_i),
  .mask_i         (mask_i),
  .isr_i          (isr_i),
  .base_i         (base_i),
  .special_mask_i (special_mask_i),
  .nest_cascade_i (nest_cascade_i),
  .is_master_i    (is_master_i),
  .valid_o        (valid_o),
  .line_o         (line_o),
  .irq_o          (irq_o)
);

// File: tb/tb_rot_prio_resolver.sv
`timescale 1ns/1ps
module tb_rot_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, isr = '0;
  logic [2:0] base = '0;
  logic       smm = 1'b0, nest = 1'b0, master = 1'b0;
  logic       valid;
  logic [2:0] line;
  logic       irq;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rot_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .isr_i(isr),
    .base_i(base), .special_mask_i(smm), .nest_cascade_i(nest),
    .is_master_i(master), .valid_o(valid), .line_o(line), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: walk ranks from the base outward
  task automatic ref_res(output bit v, output int l);
    int best = 8, svc = 8;
    for (int r = 7; r >= 0; r--) begin
      int n = (base + r) % 8;
      bit counts = isr[n];
      if (smm && mask[n]) counts = 0;
      if (nest && master && n == 2) counts = 0;
      if (req[n] && !mask[n]) best = r;
      if (counts) svc = r;
    end
    v = (best < svc);
    l = v ? (base + best) % 8 : 0;
  endtask

  task automatic apply_chk(input string tag);
    bit ev; int el;
    #0.4;
    ref_res(ev, el);
    chk(valid == ev, {tag, " valid"}, valid, ev);
    chk(int'(line) == el, {tag, " line"}, line, el);
    #0.6;
  endtask

  task automatic set_in(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s,
                        input logic [2:0] b, input bit sm, input bit ne, input bit ma);
    req = r; mask = m; isr = s; base = b; smm = sm; nest = ne; master = ma;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // reset state (R7)
    set_in(8'h01, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(irq == 1'b0, "R7 reset holds irq low", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #0.3;

    // R1 rotated winner: base 5, lines 0 and 7 -> 7
    set_in(8'h81, 8'h00, 8'h00, 3'd5, 0, 0, 0); #0.4;
    chk(valid && line == 3'd7, "R1 rotated winner", line, 7); #0.6;
    // R2 all masked
    set_in(8'hFF, 8'hFF, 8'h00, 3'd2, 0, 0, 0); #0.4;
    chk(!valid, "R2 masked requests ignored", valid, 0);
    chk(line == 3'd0, "R8 idle line zero", line, 0); #0.6;
    // R3 empty service
    set_in(8'h10, 8'h00, 8'h00, 3'd6, 0, 0, 0); #0.4;
    chk(valid && line == 3'd4, "R3 idle service grants", line, 4); #0.6;
    // R4 equal rank blocked, lower rank blocked, better rank wins
    set_in(8'h08, 8'h00, 8'h08, 3'd3, 0, 0, 0); #0.4;
    chk(!valid, "R4 equal rank blocked", valid, 0); #0.6;
    set_in(8'h04, 8'h00, 8'h08, 3'd3, 0, 0, 0); #0.4;
    chk(!valid, "R4 worse rank blocked", valid, 0); #0.6;
    set_in(8'h02, 8'h00, 8'h04, 3'd3, 0, 0, 0); #0.4;
    chk(valid && line == 3'd1, "R4 better rank wins", line, 1); #0.6;
    // R5 special mask
    set_in(8'h10, 8'h02, 8'h02, 3'd0, 1, 0, 0); #0.4;
    chk(valid && line == 3'd4, "R5 masked service ignored", line, 4); #0.6;
    set_in(8'h10, 8'h02, 8'h02, 3'd0, 0, 0, 0); #0.4;
    chk(!valid, "R5 off service counts", valid, 0); #0.6;
    // R6 cascade exclusion only on master
    set_in(8'h20, 8'h00, 8'h04, 3'd0, 0, 1, 1); #0.4;
    chk(valid && line == 3'd5, "R6 master skips cascade", line, 5); #0.6;
    set_in(8'h20, 8'h00, 8'h04, 3'd0, 0, 1, 0); #0.4;
    chk(!valid, "R6 slave keeps cascade", valid, 0); #0.6;
    set_in(8'h20, 8'h00, 8'h04, 3'd0, 0, 0, 1); #0.4;
    chk(!valid, "R6 option off keeps cascade", valid, 0); #0.6;

    // R7 registered irq: change at negedge, sample after the edge
    @(negedge clk);
    set_in(8'h01, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    #1; chk(irq == 1'b0, "R7 irq not before edge", irq, 0);
    @(posedge clk); #1;
    chk(irq == 1'b1, "R7 irq after edge", irq, 1);
    @(negedge clk);
    req = 8'h00;
    #1; chk(irq == 1'b1, "R7 irq holds until edge", irq, 1);
    @(posedge clk); #1;
    chk(irq == 1'b0, "R7 irq drops after edge", irq, 0);
    @(negedge clk); #0.3;

    // R9 / R1 exhaustive sweep, options off
    for (int b = 0; b < 8; b++)
      for (int r = 0; r < 256; r++)
        for (int s = 0; s < 256; s++) begin
          set_in(r[7:0], 8'h00, s[7:0], b[2:0], 0, 0, 0);
          apply_chk("R9 R1 sweep");
        end

    // R2 R5 R6 random patterns with options
    for (int k = 0; k < 20000; k++) begin
      int unsigned w = $urandom;
      int unsigned x = $urandom;
      set_in(w[7:0], w[15:8], w[23:16], x[2:0], x[3], x[4], x[5]);
      apply_chk("R2 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule